// File: doc/BRIEF.md
# Radix-2 Fixed-Point Square Root Unit

This block computes the square root of a normalised fixed-point operand. It produces one root bit per clock cycle, starting with the most significant bit. The operand is an unsigned fraction of `2*RW` bits with value `x / 2^(2*RW)`, and it must lie in [1/4, 1). The root is then an `RW`-bit fraction in [1/2, 1). A client pulses `start` with the operand and waits for the one-cycle `done` pulse. At that point `root` and `remainder` hold the result until the next completion.

Inside, a partial remainder and a partial root are kept in registers. In each iteration the next two operand bits enter the remainder, a trial term is formed from the partial root, and the sign of the result picks the next root bit. The `MODE` parameter selects the variant that is built around one shared step datapath. Restoring mode discards a negative trial. Non-restoring mode keeps the negative remainder and adds on the next step instead of subtracting. A final sign check then repairs the remainder.

Top module: `sqrt_unit`

## Requirements
- R1: For any operand x with its top two bits not both 0, `root` equals the largest integer q with q*q <= x. This means q*q <= x < (q+1)*(q+1), with x read as an integer of 2*RW bits and q as an integer of RW bits.
- R2: For every legal operand, bit RW-1 of `root` is 1, so the root lies in [1/2, 1).
- R3: `remainder` equals x - q*q. It is always in the range 0 to 2*q.
- R4: In restoring mode, when the trial result is negative the root bit is 0 and the remainder from before the trial is kept. Otherwise the root bit is 1 and the trial result becomes the new remainder. The partial remainder never goes negative.
- R5: In non-restoring mode, a negative remainder is kept and the next step adds the trial term instead of subtracting it. A negative final remainder is corrected by adding 2*q+1. Root and remainder match restoring mode for every operand.
- R6: `done` is high in the cycle after the (RW+1)-th rising edge that follows the edge which accepted `start`. `busy` is high from the edge that accepts `start` until `done` rises.
- R7: `done` is high for exactly one cycle. `root` and `remainder` keep their values until the next operation completes.
- R8: While `busy` is high, `start` and `operand` are ignored. The running operation finishes with its own operand and its own timing.
- R9: After reset, `busy`, `done`, `root` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation; accepted only when not busy |
| operand | input | 2*RW | Radicand, unsigned fraction in [1/4, 1) |
| busy | output | 1 | A computation is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| root | output | RW | Square root, unsigned fraction in [1/2, 1) |
| remainder | output | RW+1 | operand - root*root in integer units |

## Verification
Both variants are driven with the same operands and compared against an integer square root that the bench computes itself.

The operands fall into several groups:
- **Exact squares** (`16384`, `36864`, `65025`) give a zero remainder. They catch an off-by-one in the last digit.
- **Neighbours of squares** (`16385`, `65024`, `65535`) push the remainder to its extremes of 1 and 2*q. They show whether the final non-restoring correction fires correctly.
- **Lower bound** (`16384`) yields many zero digits, so it exercises the restoring path that keeps the old remainder.
- **Pseudo-random legal operands** mix positive and negative intermediate remainders.

Further runs check the latency, the width of the `done` pulse, result holding, and a `start` pulse injected mid-run with a different operand.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;

  typedef enum logic {
    SQ_RESTORE = 1'b0,
    SQ_NONREST = 1'b1
  } sqrt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIN  = 2'd2
  } sqrt_state_e;

endpackage

// File: rtl/sqrt_step.sv
// One radix-2 digit step: bring in two operand bits, form the trial term
// from the partial root, choose the next root bit from the sign.
module sqrt_step
  import sqrt_pkg::*;
#(
  parameter int         RW   = 8,
  parameter sqrt_mode_e MODE = SQ_RESTORE,
  parameter int         RMW  = RW + 4
) (
  input  logic signed [RMW-1:0] rem_i,
  input  logic        [RW-1:0]  root_i,
  input  logic        [1:0]     pair_i,
  output logic signed [RMW-1:0] rem_o,
  output logic        [RW-1:0]  root_o,
  output logic                  trial_neg_o,
  output logic                  add_step_o
);

  // remainder * 4 + next operand pair
  function automatic logic signed [RMW-1:0] shift_in(
    input logic signed [RMW-1:0] r, input logic [1:0] p);
    return {r[RMW-3:0], p};
  endfunction

  // 4q + 1 : subtracted when the remainder is non-negative
  function automatic logic signed [RMW-1:0] sub_term(input logic [RW-1:0] q);
    return $signed({{(RMW-RW-2){1'b0}}, q, 2'b01});
  endfunction

  // 4q + 3 : added when the remainder is negative (non-restoring only)
  function automatic logic signed [RMW-1:0] add_term(input logic [RW-1:0] q);
    return $signed({{(RMW-RW-2){1'b0}}, q, 2'b11});
  endfunction

  logic signed [RMW-1:0] shifted;
  logic signed [RMW-1:0] trial;

  assign shifted = shift_in(rem_i, pair_i);

  generate
    if (MODE == SQ_RESTORE) begin : g_restore
      always_comb begin
        add_step_o  = 1'b0;
        trial       = shifted - sub_term(root_i);
        trial_neg_o = trial[RMW-1];
        rem_o       = trial_neg_o ? shifted : trial;
        root_o      = {root_i[RW-2:0], ~trial_neg_o};
      end
    end else begin : g_nonrest
      always_comb begin
        add_step_o  = rem_i[RMW-1];
        trial       = add_step_o ? (shifted + add_term(root_i))
                                 : (shifted - sub_term(root_i));
        trial_neg_o = trial[RMW-1];
        rem_o       = trial;
        root_o      = {root_i[RW-2:0], ~trial_neg_o};
      end
    end
  endgenerate

endmodule

// File: rtl/sqrt_unit.sv
module sqrt_unit
  import sqrt_pkg::*;
#(
  parameter int         RW   = 8,
  parameter sqrt_mode_e MODE = SQ_RESTORE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*RW-1:0] operand,
  output logic            busy,
  output logic            done,
  output logic [RW-1:0]   root,
  output logic [RW:0]     remainder
);

  localparam int OW  = 2 * RW;
  localparam int RMW = RW + 4;
  localparam int CW  = (RW > 2) ? $clog2(RW) : 1;

  sqrt_state_e           state_q;
  logic [OW-1:0]         opnd_q;
  logic signed [RMW-1:0] rem_q, rem_nx, rem_fix;
  logic [RW-1:0]         root_q, root_nx;
  logic [CW-1:0]         cnt_q;
  logic                  trial_neg, add_step;
  logic                  accept, last_step;

  assign accept    = (state_q == ST_IDLE) && start;
  assign last_step = (cnt_q == CW'(RW - 1));
  assign busy      = (state_q != ST_IDLE);

  sqrt_step #(.RW(RW), .MODE(MODE), .RMW(RMW)) u_step (
    .rem_i       (rem_q),
    .root_i      (root_q),
    .pair_i      (opnd_q[OW-1 -: 2]),
    .rem_o       (rem_nx),
    .root_o      (root_nx),
    .trial_neg_o (trial_neg),
    .add_step_o  (add_step)
  );

  // final remainder sign check
  generate
    if (MODE == SQ_NONREST) begin : g_fix
      assign rem_fix = rem_q[RMW-1]
        ? rem_q + $signed({{(RMW-RW-1){1'b0}}, root_q, 1'b1})
        : rem_q;
    end else begin : g_nofix
      assign rem_fix = rem_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      opnd_q    <= '0;
      rem_q     <= '0;
      root_q    <= '0;
      cnt_q     <= '0;
      done      <= 1'b0;
      root      <= '0;
      remainder <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            opnd_q  <= operand;
            rem_q   <= '0;
            root_q  <= '0;
            cnt_q   <= '0;
            state_q <= ST_ITER;
          end
        end
        ST_ITER: begin
          rem_q  <= rem_nx;
          root_q <= root_nx;
          opnd_q <= {opnd_q[OW-3:0], 2'b00};
          if (last_step) state_q <= ST_FIN;
          else           cnt_q   <= cnt_q + 1'b1;
        end
        ST_FIN: begin
          root      <= root_q;
          remainder <= rem_fix[RW:0];
          done      <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_root_msb_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> root[RW-1]);

  assert_rem_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, remainder} <= {root, 1'b0}));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (cnt_q != '0));

  generate
    if (MODE == SQ_RESTORE) begin : g_chk_restore
      assert_rem_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER) |-> !rem_q[RMW-1]);
      assert_neg_digit_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && trial_neg) |=> (root_q[0] == 1'b0));
    end else begin : g_chk_nonrest
      assert_fix_nonneg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIN) |-> !rem_fix[RMW-1]);
      assert_add_after_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && trial_neg && !last_step) |=> add_step);
    end
  endgenerate

endmodule

// File: tb/tb_sqrt_unit.sv
module tb_sqrt_unit;
  import sqrt_pkg::*;

  localparam int RW         = 8;
  localparam int OW         = 2 * RW;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;

  localparam logic [OW-1:0] VEC_X [NVEC] = '{
    16'd16384, 16'd65535, 16'd65025, 16'd65024, 16'd16385,
    16'd36864, 16'd40000, 16'd20000, 16'd50000, 16'd30000};
  localparam logic [RW-1:0] VEC_Q [NVEC] = '{
    8'd128, 8'd255, 8'd255, 8'd254, 8'd128,
    8'd192, 8'd200, 8'd141, 8'd223, 8'd173};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [OW-1:0] operand = '0;
  logic busy_r, done_r, busy_n, done_n;
  logic [RW-1:0] root_r, root_n;
  logic [RW:0] rem_r, rem_n;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqrt_unit #(.RW(RW), .MODE(SQ_RESTORE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy_r), .done(done_r), .root(root_r), .remainder(rem_r));

  sqrt_unit #(.RW(RW), .MODE(SQ_NONREST)) dut_nr (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .busy(busy_n), .done(done_n), .root(root_n), .remainder(rem_n));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int int_root(input int x);
    int q = 0;
    while ((q + 1) * (q + 1) <= x) q++;
    return q;
  endfunction

  // Issue one operation; optionally poke start mid-run with another operand.
  task automatic run_op(input logic [OW-1:0] x, input bit poke, output int lat);
    @(negedge clk);
    start = 1'b1; operand = x;
    @(negedge clk);
    start = 1'b0; operand = '0;
    check(busy_r && busy_n, "R6 busy after accept", int'(busy_r), 1);
    lat = 0;
    while (!done_r && lat < RW + 8) begin
      if (poke && lat == 2) begin start = 1'b1; operand = 16'hFFFF; end
      else begin start = 1'b0; operand = '0; end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic verify(input logic [OW-1:0] x, input int exp_q, input int lat, input string tag);
    int exp_r;
    exp_r = int'(x) - exp_q * exp_q;
    check(int'(root_r) == exp_q, {"R1 root ", tag}, int'(root_r), exp_q);
    check(int'(rem_r) == exp_r, {"R3 remainder ", tag}, int'(rem_r), exp_r);
    check(root_r[RW-1] == 1'b1, {"R2 root msb ", tag}, int'(root_r[RW-1]), 1);
    check(int'(root_n) == exp_q, {"R5 nonrestoring root ", tag}, int'(root_n), exp_q);
    check(int'(rem_n) == exp_r, {"R5 nonrestoring remainder ", tag}, int'(rem_n), exp_r);
    check(lat == RW + 1, {"R6 latency ", tag}, lat, RW + 1);
    check(done_n == 1'b1, {"R6 nonrestoring done ", tag}, int'(done_n), 1);
  endtask

  initial begin
    int lat;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy_r && !done_r && root_r == '0 && rem_r == '0, "R9 reset outputs",
          int'(root_r) + int'(rem_r) + int'(busy_r) + int'(done_r), 0);
    check(!busy_n && !done_n && root_n == '0 && rem_n == '0, "R9 reset outputs nonrestoring",
          int'(root_n) + int'(rem_n) + int'(busy_n) + int'(done_n), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table: R1 R3 R4 R5 R6
    for (int i = 0; i < NVEC; i++) begin
      run_op(VEC_X[i], 1'b0, lat);
      check(int'(VEC_Q[i]) == int_root(int'(VEC_X[i])), "R1 table entry",
            int'(VEC_Q[i]), int_root(int'(VEC_X[i])));
      verify(VEC_X[i], int'(VEC_Q[i]), lat, "table");
    end

    // R7: one-cycle done, result held
    @(negedge clk);
    check(!done_r && !done_n, "R7 done width", int'(done_r), 0);
    check(int'(root_r) == 173 && int'(root_n) == 173, "R7 root held", int'(root_r), 173);
    repeat (4) @(negedge clk);
    check(int'(rem_r) == 71, "R7 remainder held", int'(rem_r), 71);

    // R8: start mid-run with another operand is ignored
    run_op(16'd16385, 1'b1, lat);
    verify(16'd16385, 128, lat, "start while busy R8");
    @(negedge clk);
    check(!busy_r && !done_r, "R8 no restart after poke", int'(busy_r), 0);

    // pseudo-random legal operands: R1 R3 R5
    lfsr = 16'hACE1;
    for (int k = 0; k < 40; k++) begin
      logic [OW-1:0] x;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x = lfsr;
      if (x[OW-1:OW-2] == 2'b00) x[OW-2] = 1'b1;
      run_op(x, 1'b0, lat);
      verify(x, int_root(int'(x)), lat, "random");
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule